// File: doc/BRIEF.md
# Compare-Based Jump Condition Evaluator

This block decides whether a conditional jump is taken, using the zero flag and carry flag stored by an earlier compare. The compare computed A minus B with an inverted carry sense, so a set carry flag means a borrow occurred. That gives three valid flag pairs: less-than (Z=0, C=1), equal (Z=1, C=0) and greater-than (Z=0, C=0). The fourth pair, Z=1 with C=1, cannot come from a compare and is treated as no valid relation.

A 4-bit jump-type code selects the condition to test. The block first turns the flag pair into a one-hot relation, then matches that relation against the selected condition. The decision is registered once, so the take-branch output is valid one clock after the code and flags are presented. Updating the program counter and fetching instructions belong to the surrounding control logic.

Top module: `jcond_eval`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it is released, take_branch is 0.
- R2: take_branch reflects jump_code, flag_z and flag_c as sampled on the previous rising clock edge.
- R3: Code 0 (unconditional jump) is taken for every flag pair.
- R4: Code 3 (jump if equal) and code 1 (jump if zero) are taken exactly when Z=1 and C=0.
- R5: Code 4 (jump if not equal) and code 2 (jump if not zero) are taken exactly when Z=0, whatever the value of C.
- R6: Code 5 (jump if less) is taken exactly when Z=0 and C=1.
- R7: Code 6 (jump if greater) is taken exactly when Z=0 and C=0.
- R8: Code 7 (jump if less or equal) is taken exactly when Z=0 and C=1, or when Z=1 and C=0.
- R9: Code 8 (jump if greater or equal) is taken exactly when C=0 and Z is either value.
- R10: The flag pair Z=1, C=1 makes codes 1 through 8 not taken.
- R11: Codes 9 through 15 are unassigned and are never taken.
- R12: The flags left by a two-byte chained compare of 0xAA01 against 0xAA02 (C=1, Z=0) make less-than and not-equal taken, and equal and greater-than not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_code | input | 4 | Selects which jump condition to test |
| flag_z | input | 1 | Stored zero flag from the last compare |
| flag_c | input | 1 | Stored carry flag; 1 means a borrow occurred in A minus B |
| take_branch | output | 1 | Registered decision: 1 means the jump is taken |

## Verification
All sixteen codes are swept against all four flag pairs. This separates each condition from its neighbours: less from less-or-equal on the equal pair, not-equal from greater on the less pair, and every conditional jump from the unconditional one on the invalid pair. A chained two-byte compare is modelled arithmetically in the bench, and the flags it yields show that the ordering conditions follow the inverted carry sense. Back-to-back changes of code and flags on consecutive cycles confirm that the output follows the previous edge's inputs, with no later or stale values.

// File: rtl/jcond_pkg.sv
package jcond_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        JC_ALWAYS = 4'd0,
        JC_ZERO   = 4'd1,
        JC_NZERO  = 4'd2,
        JC_EQ     = 4'd3,
        JC_NE     = 4'd4,
        JC_LT     = 4'd5,
        JC_GT     = 4'd6,
        JC_LE     = 4'd7,
        JC_GE     = 4'd8
    } jcode_e;

    localparam logic [CODE_W-1:0] LAST_CODE = JC_GE;

    // One-hot relation recovered from the stored flags; all zero when the
    // flag pair could not have come from a compare.
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
    } rel_t;

    typedef struct packed {
        logic take;
    } eval_state_t;

endpackage

// File: rtl/jcond_rel_decode.sv
module jcond_rel_decode
    import jcond_pkg::*;
(
    input  logic flag_z,
    input  logic flag_c,
    output rel_t rel
);

    // Inverted carry: C=1 marks a borrow, so A<B.
    always_comb begin
        rel    = '0;
        rel.lt = !flag_z &&  flag_c;
        rel.eq =  flag_z && !flag_c;
        rel.gt = !flag_z && !flag_c;
    end

    always_comb begin
        if (!(flag_z && flag_c))
            a_rel_valid_r10: assert ($onehot({rel.lt, rel.eq, rel.gt}));
    end

endmodule

// File: rtl/jcond_select.sv
module jcond_select
    import jcond_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  rel_t              rel,
    output logic              take
);

    always_comb begin
        case (code)
            JC_ALWAYS:        take = 1'b1;
            JC_ZERO, JC_EQ:   take = rel.eq;
            JC_NZERO, JC_NE:  take = rel.lt | rel.gt;
            JC_LT:            take = rel.lt;
            JC_GT:            take = rel.gt;
            JC_LE:            take = rel.lt | rel.eq;
            JC_GE:            take = rel.gt | rel.eq;
            default:          take = 1'b0;
        endcase
    end

endmodule

// File: rtl/jcond_eval.sv
module jcond_eval
    import jcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] jump_code,
    input  logic              flag_z,
    input  logic              flag_c,
    output logic              take_branch
);

    rel_t        rel;
    logic        take_comb;
    eval_state_t st_d;
    eval_state_t st_q;

    jcond_rel_decode u_decode (
        .flag_z (flag_z),
        .flag_c (flag_c),
        .rel    (rel)
    );

    jcond_select u_select (
        .code (jump_code),
        .rel  (rel),
        .take (take_comb)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = take_comb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_branch = st_q.take;

    p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        jump_code == JC_ALWAYS |=> take_branch);

    p_bad_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_z && flag_c && jump_code != JC_ALWAYS) |=> !take_branch);

    p_unassigned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_code > LAST_CODE) |=> !take_branch);

    p_less_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_code == JC_LT && !flag_z && flag_c) |=> take_branch);

    p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((jump_code == JC_EQ || jump_code == JC_ZERO) && flag_z && !flag_c)
        |=> take_branch);

    p_ge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_code == JC_GE && flag_c) |=> !take_branch);

endmodule

// File: tb/jcond_eval_tb_top.sv
module jcond_eval_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] jump_code = 4'd0;
    logic       flag_z = 1'b0;
    logic       flag_c = 1'b0;
    logic       take_branch;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    jcond_eval dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .jump_code   (jump_code),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .take_branch (take_branch)
    );

    function automatic logic expect_take(input logic [3:0] code, input logic z, input logic c);
        logic lt, eq, gt;
        lt = !z && c;
        eq = z && !c;
        gt = !z && !c;
        case (code)
            4'd0:       return 1'b1;            // R3
            4'd1, 4'd3: return eq;              // R4
            4'd2, 4'd4: return lt || gt;        // R5
            4'd5:       return lt;              // R6
            4'd6:       return gt;              // R7
            4'd7:       return lt || eq;        // R8
            4'd8:       return gt || eq;        // R9
            default:    return 1'b0;            // R11
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] code, input logic z, input logic c);
        if (code > 4'd8) return "R11";
        if (code == 4'd0) return "R3";
        if (z && c) return "R10";
        case (code)
            4'd1, 4'd3: return "R4";
            4'd2, 4'd4: return "R5";
            4'd5:       return "R6";
            4'd6:       return "R7";
            4'd7:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: take_branch=%0b expected=%0b (code=%0d z=%0b c=%0b)",
                     req, act, exp, jump_code, flag_z, flag_c);
        end
    endtask

    // Drive on the falling edge, check just after the next rising edge.
    task automatic apply(input logic [3:0] code, input logic z, input logic c, input string req);
        @(negedge clk);
        jump_code = code;
        flag_z    = z;
        flag_c    = c;
        @(posedge clk);
        #1;
        check(req, take_branch, expect_take(code, z, c));
    endtask

    initial begin
        logic [7:0] a_lo, b_lo, a_hi, b_hi;
        logic [8:0] diff;
        logic       cz, cc;

        // R1: reset holds output low even with an always-taken code
        jump_code = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", take_branch, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        jump_code = 4'd15;
        @(posedge clk);
        #1;
        check("R1", take_branch, 1'b0);

        // Full sweep: R3..R11, consecutive cycles exercise R2
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 4; f++) begin
                apply(4'(code), f[1], f[0], req_of(4'(code), f[1], f[0]));
            end
        end

        // R2: alternating taken / not taken on back-to-back cycles
        for (int k = 0; k < 8; k++) begin
            apply(k[0] ? 4'd0 : 4'd12, 1'b0, 1'b0, "R2");
        end

        // R12: chained compare 0xAA01 vs 0xAA02, C=1 meaning borrow
        a_lo = 8'h01; b_lo = 8'h02; a_hi = 8'hAA; b_hi = 8'hAA;
        diff = {1'b0, a_lo} - {1'b0, b_lo};
        cc   = diff[8];
        diff = {1'b0, a_hi} - {1'b0, b_hi} - {8'd0, cc};
        cc   = diff[8];
        cz   = (diff[7:0] == 8'd0);
        n_checks++;
        if (!(cc == 1'b1 && cz == 1'b0)) begin
            n_fail++;
            $display("FAIL R12: bench flags z=%0b c=%0b expected z=0 c=1", cz, cc);
        end
        apply(4'd5, cz, cc, "R12");
        check("R12", take_branch, 1'b1);
        apply(4'd4, cz, cc, "R12");
        check("R12", take_branch, 1'b1);
        apply(4'd3, cz, cc, "R12");
        check("R12", take_branch, 1'b0);
        apply(4'd6, cz, cc, "R12");
        check("R12", take_branch, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule